// File: doc/BRIEF.md
# Clock Divider Update Sequencer

This block is the digital control of a clock generation unit. It keeps the active divisor for each of several derived clocks and produces one clock-enable strobe per derived clock. After reset it is in bypass: the strobes simply follow the per-output gate controls every cycle, so each derived clock runs at the reference rate and the divisors have no effect. Software switches it to normal mode once the full-speed settings are in place. In normal mode each strobe fires once every N cycles, where N is the divisor of that output.

A divisor write does not take effect at once. It is held as pending. A sequencer then waits until the PLL lock input has stayed high for a set number of consecutive cycles, and copies all pending divisors into the active set in the same cycle. That cycle restarts every divider, so all enabled outputs share one common edge. The block then emits a one-cycle completion event, latches it in a status bit and drives a wake request from that bit.

A write that arrives while an update is running and the PLL is locked is refused. The refused write sets a sticky error flag. Software clears the flag and then repeats the write.

Top module: `clkdiv_seq_top`

## Requirements
- R1: After reset the block is in bypass (`normal_o`=0), all active divisors are 0, and `busy_o`, `err_o`, `evt_o`, `evt_sts_o` and `wake_o` are 0.
- R2: In bypass, `clk_en_o` equals `gate_en_i` in every cycle, whatever divisors are active.
- R3: In normal mode, output i strobes once every E cycles, where E is its active divisor and a divisor of 0 counts as 1. `clk_en_o[i]` is 0 whenever `gate_en_i[i]` is 0.
- R4: A divisor write accepted while idle raises `busy_o` and holds the value as pending. If lock stays high, `div_o` takes the pending value and `evt_o` pulses SETTLE_CYC+1 rising edges after the edge that samples the write. `div_o` changes at no other time.
- R5: In the cycle where `evt_o` is high, every gated output strobes together. The following strobes of output i come every E_i cycles from that common edge.
- R6: A divisor write while `busy_o`=1 and `lock_i`=1 is refused. It sets `err_o`, and the update already running applies its own value unchanged.
- R7: A divisor write while `busy_o`=1 and `lock_i`=0 replaces the pending value, restarts the wait for lock and does not set `err_o`.
- R8: If lock drops while the block is waiting for the settle count, the count restarts. The update applies only after SETTLE_CYC consecutive locked cycles following the return of lock.
- R9: `err_o` is cleared by a one-cycle pulse on `err_clr_i`. If a new error occurs in the same cycle as the clear, the bit stays set.
- R10: `evt_o` is high for one cycle per update. `evt_sts_o` sets with it and holds until `evt_clr_i` is pulsed; a new event in the same cycle as the clear wins. `wake_o` equals `evt_sts_o`.
- R11: A pulse on `mode_wr_i` loads `mode_normal_i` into `normal_o` at the next edge.
- R12: Output i takes its divisor from bits [i*DIV_W +: DIV_W] of `div_data_i`, and `div_o` uses the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_i | input | 1 | PLL lock indication |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_normal_i | input | 1 | Mode value: 1 normal, 0 bypass |
| div_wr_i | input | 1 | Divisor write strobe |
| div_data_i | input | NUM_OUT*DIV_W | Packed divisor values |
| err_clr_i | input | 1 | Clear for the error flag (write one) |
| evt_clr_i | input | 1 | Clear for the event status (write one) |
| gate_en_i | input | NUM_OUT | Per-output clock gating enable |
| normal_o | output | 1 | 1 while in normal mode |
| busy_o | output | 1 | Update sequence in progress |
| div_o | output | NUM_OUT*DIV_W | Active divisors |
| clk_en_o | output | NUM_OUT | Per-output clock-enable strobes |
| evt_o | output | 1 | Single-cycle completion event |
| evt_sts_o | output | 1 | Latched completion status |
| wake_o | output | 1 | Wake request to the core |
| err_o | output | 1 | Sticky refused-write error |

## Verification
A sequencer stuck in the wrong state shows up at the ports within SETTLE_CYC+2 cycles of a write. The symptom is either a missing completion event or one that arrives at the wrong edge count, and the bench measures that count for every update. A wrong divider phase or reload value shows up in normal mode at the first strobe after the common edge, because every cycle is compared against a period model started at the event. A refused write that slips through shows up as a wrong `div_o` at the next event, and a lost or wrongly cleared error or status bit is seen in the cycle after the clear.

// File: rtl/cds_pkg.sv
`timescale 1ns/1ps
package cds_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_WAIT   = 2'd1,
      SQ_SETTLE = 2'd2
   } sq_state_t;
endpackage

// File: rtl/cds_seq.sv
`timescale 1ns/1ps
// Update sequencer: pending divisors, lock wait, settle count, error flag.
module cds_seq #(
   parameter int NUM_OUT    = 3,
   parameter int DIV_W      = 4,
   parameter int SETTLE_CYC = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       lock_i,
   input  logic                       div_wr_i,
   input  logic [NUM_OUT*DIV_W-1:0]   div_data_i,
   input  logic                       err_clr_i,
   output logic [NUM_OUT*DIV_W-1:0]   pend_o,
   output logic                       apply_o,
   output logic                       busy_o,
   output logic                       err_o
);
   import cds_pkg::*;

   localparam int TOT = NUM_OUT * DIV_W;
   localparam int SCW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
   localparam logic [SCW-1:0] SC_LAST = SCW'(SETTLE_CYC - 1);

   sq_state_t      state_q;
   logic [SCW-1:0] scnt_q;
   logic [TOT-1:0] pend_q;
   logic           err_q;
   logic           wr_ok;
   logic           wr_bad;
   logic           apply;

   always_comb begin
      wr_ok  = div_wr_i && ((state_q == SQ_IDLE) || !lock_i);
      wr_bad = div_wr_i && (state_q != SQ_IDLE) && lock_i;
      apply  = (state_q == SQ_SETTLE) && lock_i && (scnt_q == SC_LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         scnt_q  <= '0;
         pend_q  <= '0;
      end else if (wr_ok) begin
         pend_q  <= div_data_i;
         state_q <= SQ_WAIT;
         scnt_q  <= '0;
      end else begin
         case (state_q)
            SQ_WAIT: begin
               if (lock_i) begin
                  state_q <= SQ_SETTLE;
                  scnt_q  <= '0;
               end
            end
            SQ_SETTLE: begin
               if (!lock_i) begin
                  state_q <= SQ_WAIT;
                  scnt_q  <= '0;
               end else if (apply) begin
                  state_q <= SQ_IDLE;
                  scnt_q  <= '0;
               end else begin
                  scnt_q  <= scnt_q + SCW'(1);
               end
            end
            default: begin
               state_q <= SQ_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= wr_bad | (err_q & ~err_clr_i);
   end

   assign pend_o  = pend_q;
   assign apply_o = apply;
   assign busy_o  = (state_q != SQ_IDLE);
   assign err_o   = err_q;
endmodule

// File: rtl/cds_div.sv
`timescale 1ns/1ps
// Active divisor registers and one period counter per derived clock.
module cds_div #(
   parameter int NUM_OUT = 3,
   parameter int DIV_W   = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     apply_i,
   input  logic [NUM_OUT*DIV_W-1:0] pend_i,
   output logic [NUM_OUT*DIV_W-1:0] div_o,
   output logic [NUM_OUT-1:0]       stb_o
);
   for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_out
      logic [DIV_W-1:0] act_q;
      logic [DIV_W-1:0] cnt_q;
      logic [DIV_W-1:0] reload;

      // zero is treated as divide-by-one
      assign reload = (act_q == '0) ? '0 : act_q - DIV_W'(1);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_q <= '0;
            cnt_q <= '0;
         end else if (apply_i) begin
            act_q <= pend_i[gi*DIV_W +: DIV_W];
            cnt_q <= '0;
         end else if (cnt_q == '0) begin
            cnt_q <= reload;
         end else begin
            cnt_q <= cnt_q - DIV_W'(1);
         end
      end

      assign stb_o[gi]                 = (cnt_q == '0);
      assign div_o[gi*DIV_W +: DIV_W]  = act_q;
   end
endmodule

// File: rtl/cds_mode.sv
`timescale 1ns/1ps
// Mode register and per-output gating of the strobes.
module cds_mode #(
   parameter int NUM_OUT = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_wr_i,
   input  logic               mode_normal_i,
   input  logic [NUM_OUT-1:0] gate_en_i,
   input  logic [NUM_OUT-1:0] stb_i,
   output logic               normal_o,
   output logic [NUM_OUT-1:0] clk_en_o
);
   logic normal_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         normal_q <= 1'b0;
      else if (mode_wr_i) normal_q <= mode_normal_i;
   end

   for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_gate
      assign clk_en_o[gi] = gate_en_i[gi] & (normal_q ? stb_i[gi] : 1'b1);
   end

   assign normal_o = normal_q;
endmodule

// File: rtl/cds_evt.sv
`timescale 1ns/1ps
// Completion event pulse and latched status.
module cds_evt (
   input  logic clk,
   input  logic rst_n,
   input  logic apply_i,
   input  logic evt_clr_i,
   output logic evt_o,
   output logic evt_sts_o
);
   logic evt_q;
   logic sts_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_q <= 1'b0;
         sts_q <= 1'b0;
      end else begin
         evt_q <= apply_i;
         sts_q <= apply_i | (sts_q & ~evt_clr_i);
      end
   end

   assign evt_o     = evt_q;
   assign evt_sts_o = sts_q;
endmodule

// File: rtl/clkdiv_seq_top.sv
`timescale 1ns/1ps
module clkdiv_seq_top #(
   parameter int NUM_OUT    = 3,
   parameter int DIV_W      = 4,
   parameter int SETTLE_CYC = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     lock_i,
   input  logic                     mode_wr_i,
   input  logic                     mode_normal_i,
   input  logic                     div_wr_i,
   input  logic [NUM_OUT*DIV_W-1:0] div_data_i,
   input  logic                     err_clr_i,
   input  logic                     evt_clr_i,
   input  logic [NUM_OUT-1:0]       gate_en_i,
   output logic                     normal_o,
   output logic                     busy_o,
   output logic [NUM_OUT*DIV_W-1:0] div_o,
   output logic [NUM_OUT-1:0]       clk_en_o,
   output logic                     evt_o,
   output logic                     evt_sts_o,
   output logic                     wake_o,
   output logic                     err_o
);
   localparam int TOT = NUM_OUT * DIV_W;

   if (NUM_OUT < 1)    begin : g_bad_nout   $error("NUM_OUT must be at least 1");    end
   if (DIV_W < 1)      begin : g_bad_divw   $error("DIV_W must be at least 1");      end
   if (SETTLE_CYC < 1) begin : g_bad_settle $error("SETTLE_CYC must be at least 1"); end

   logic [TOT-1:0]     pend;
   logic               apply;
   logic [NUM_OUT-1:0] stb;

   cds_seq #(.NUM_OUT(NUM_OUT), .DIV_W(DIV_W), .SETTLE_CYC(SETTLE_CYC)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .lock_i     (lock_i),
      .div_wr_i   (div_wr_i),
      .div_data_i (div_data_i),
      .err_clr_i  (err_clr_i),
      .pend_o     (pend),
      .apply_o    (apply),
      .busy_o     (busy_o),
      .err_o      (err_o)
   );

   cds_div #(.NUM_OUT(NUM_OUT), .DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .apply_i (apply),
      .pend_i  (pend),
      .div_o   (div_o),
      .stb_o   (stb)
   );

   cds_mode #(.NUM_OUT(NUM_OUT)) u_mode (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_wr_i     (mode_wr_i),
      .mode_normal_i (mode_normal_i),
      .gate_en_i     (gate_en_i),
      .stb_i         (stb),
      .normal_o      (normal_o),
      .clk_en_o      (clk_en_o)
   );

   cds_evt u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .apply_i   (apply),
      .evt_clr_i (evt_clr_i),
      .evt_o     (evt_o),
      .evt_sts_o (evt_sts_o)
   );

   assign wake_o = evt_sts_o;
endmodule

// File: rtl/cds_checker.sv
`timescale 1ns/1ps
module cds_checker #(
   parameter int NUM_OUT = 3,
   parameter int DIV_W   = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     lock_i,
   input logic                     mode_wr_i,
   input logic                     mode_normal_i,
   input logic                     div_wr_i,
   input logic                     err_clr_i,
   input logic [NUM_OUT-1:0]       gate_en_i,
   input logic                     normal_o,
   input logic                     busy_o,
   input logic [NUM_OUT*DIV_W-1:0] div_o,
   input logic [NUM_OUT-1:0]       clk_en_o,
   input logic                     evt_o,
   input logic                     evt_sts_o,
   input logic                     err_o
);
   p_bypass_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !normal_o |-> clk_en_o == gate_en_i);

   p_div_only_on_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_o) |-> evt_o);

   p_common_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o && normal_o) |-> clk_en_o == gate_en_i);

   p_reject_sets_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && div_wr_i && lock_i) |=> err_o);

   p_unlocked_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && div_wr_i && !lock_i && !err_o) |=> !err_o);

   p_apply_needs_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |-> $past(lock_i));

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !err_clr_i) |=> err_o);

   p_evt_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |=> !evt_o);

   p_evt_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |-> evt_sts_o);

   p_mode_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr_i |=> normal_o == $past(mode_normal_i));
endmodule

bind clkdiv_seq_top cds_checker #(.NUM_OUT(NUM_OUT), .DIV_W(DIV_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .lock_i        (lock_i),
   .mode_wr_i     (mode_wr_i),
   .mode_normal_i (mode_normal_i),
   .div_wr_i      (div_wr_i),
   .err_clr_i     (err_clr_i),
   .gate_en_i     (gate_en_i),
   .normal_o      (normal_o),
   .busy_o        (busy_o),
   .div_o         (div_o),
   .clk_en_o      (clk_en_o),
   .evt_o         (evt_o),
   .evt_sts_o     (evt_sts_o),
   .err_o         (err_o)
);

// File: tb/test_clkdiv_seq_top.sv
`timescale 1ns/1ps
module test_clkdiv_seq_top;
   localparam int NO  = 3;
   localparam int DW  = 4;
   localparam int SC  = 3;
   localparam int TOT = NO * DW;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           lock_i = 1'b0;
   logic           mode_wr_i = 1'b0;
   logic           mode_normal_i = 1'b0;
   logic           div_wr_i = 1'b0;
   logic [TOT-1:0] div_data_i = '0;
   logic           err_clr_i = 1'b0;
   logic           evt_clr_i = 1'b0;
   logic [NO-1:0]  gate_en_i = '0;
   logic           normal_o, busy_o, evt_o, evt_sts_o, wake_o, err_o;
   logic [TOT-1:0] div_o;
   logic [NO-1:0]  clk_en_o;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   clkdiv_seq_top #(.NUM_OUT(NO), .DIV_W(DW), .SETTLE_CYC(SC)) i_clkdiv_seq_top (
      .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .mode_wr_i(mode_wr_i),
      .mode_normal_i(mode_normal_i), .div_wr_i(div_wr_i), .div_data_i(div_data_i),
      .err_clr_i(err_clr_i), .evt_clr_i(evt_clr_i), .gate_en_i(gate_en_i),
      .normal_o(normal_o), .busy_o(busy_o), .div_o(div_o), .clk_en_o(clk_en_o),
      .evt_o(evt_o), .evt_sts_o(evt_sts_o), .wake_o(wake_o), .err_o(err_o)
   );

   function automatic int eff_div(input logic [TOT-1:0] d, input int i);
      int v;
      v = int'(d[i*DW +: DW]);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // write divisors, then count edges until the completion event
   task automatic wr_wait(input logic [TOT-1:0] d, output int n);
      div_wr_i = 1'b1; div_data_i = d;
      step();
      div_wr_i = 1'b0;
      n = 0;
      while (n < 60) begin
         step();
         n++;
         if (evt_o) break;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      logic [TOT-1:0] a, b;
      void'($urandom(32'd4711));
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk(normal_o == 1'b0, "R1 normal", normal_o, 0);
      chk(div_o == '0, "R1 div", div_o, 0);
      chk({busy_o, err_o, evt_o, evt_sts_o, wake_o} == 5'b0, "R1 flags",
          {busy_o, err_o, evt_o, evt_sts_o, wake_o}, 0);

      // R2 bypass with nonzero divisors
      lock_i = 1'b1;
      wr_wait(12'h357, n);
      chk(n == SC + 1, "R4 latency bypass", n, SC + 1);
      chk(div_o == 12'h357, "R12 layout", div_o, 12'h357);
      evt_clr_i = 1'b1; step(); evt_clr_i = 1'b0;
      for (int k = 0; k < 16; k++) begin
         gate_en_i = NO'($urandom);
         #1;
         chk(clk_en_o == gate_en_i, "R2 bypass pass", clk_en_o, gate_en_i);
         step();
      end

      // R11 mode write
      mode_wr_i = 1'b1; mode_normal_i = 1'b1;
      step();
      mode_wr_i = 1'b0; mode_normal_i = 1'b0;
      chk(normal_o == 1'b1, "R11 mode", normal_o, 1);

      // R3 R4 R5 R10 random updates
      for (int t = 0; t < 40; t++) begin
         a = TOT'($urandom);
         if (t == 0) a = '0;
         gate_en_i = (t < 3) ? {NO{1'b1}} : NO'($urandom);
         wr_wait(a, n);
         chk(n == SC + 1, "R4 latency", n, SC + 1);
         chk(div_o == a, "R4 div applied", div_o, a);
         chk(clk_en_o == gate_en_i, "R5 common edge", clk_en_o, gate_en_i);
         chk(evt_sts_o && wake_o, "R10 status set", {evt_sts_o, wake_o}, 3);
         for (int k = 1; k <= 24; k++) begin
            logic [NO-1:0] e;
            if (k == 2) evt_clr_i = 1'b1;
            step();
            evt_clr_i = 1'b0;
            for (int i = 0; i < NO; i++)
               e[i] = gate_en_i[i] && ((k % eff_div(a, i)) == 0);
            chk(clk_en_o == e, "R3 strobe period", clk_en_o, e);
            if (k == 1) chk(evt_o == 1'b0, "R10 single pulse", evt_o, 0);
            if (k == 2) chk(evt_sts_o == 1'b0 && wake_o == 1'b0, "R10 clear",
                            {evt_sts_o, wake_o}, 0);
         end
      end

      // R6 refused write while locked
      gate_en_i = {NO{1'b1}};
      a = 12'h234; b = 12'h999;
      div_wr_i = 1'b1; div_data_i = a; step();
      div_data_i = b; step();
      div_wr_i = 1'b0;
      chk(err_o == 1'b1, "R6 err set", err_o, 1);
      n = 0;
      while (!evt_o && n < 60) begin step(); n++; end
      chk(div_o == a, "R6 refused no effect", div_o, a);

      // R9 clear with simultaneous new error keeps bit
      div_wr_i = 1'b1; div_data_i = 12'h111; step();
      div_data_i = 12'h222; err_clr_i = 1'b1; step();
      div_wr_i = 1'b0; err_clr_i = 1'b0;
      chk(err_o == 1'b1, "R9 set wins", err_o, 1);
      err_clr_i = 1'b1; step(); err_clr_i = 1'b0;
      chk(err_o == 1'b0, "R9 clear", err_o, 0);
      n = 0;
      while (busy_o && n < 60) begin step(); n++; end
      chk(div_o == 12'h111, "R6 first kept", div_o, 12'h111);

      // R7 replace while unlocked
      lock_i = 1'b0;
      div_wr_i = 1'b1; div_data_i = 12'h456; step();
      div_data_i = 12'h789; step();
      div_wr_i = 1'b0;
      chk(err_o == 1'b0, "R7 no err", err_o, 0);
      repeat (5) step();
      chk(busy_o && !evt_o, "R7 waits for lock", {busy_o, evt_o}, 2);
      lock_i = 1'b1;
      n = 0;
      while (!evt_o && n < 60) begin step(); n++; end
      chk(n == SC + 1, "R8 from lock", n, SC + 1);
      chk(div_o == 12'h789, "R7 replaced", div_o, 12'h789);

      // R8 lock drop during settle restarts the count
      div_wr_i = 1'b1; div_data_i = 12'hABC; step();
      div_wr_i = 1'b0;
      step(); step();
      lock_i = 1'b0; step();
      chk(!evt_o && busy_o, "R8 no apply on drop", {busy_o, evt_o}, 2);
      lock_i = 1'b1;
      n = 0;
      while (!evt_o && n < 60) begin step(); n++; end
      chk(n == SC + 1, "R8 restart", n, SC + 1);
      chk(div_o == 12'hABC, "R8 applied", div_o, 12'hABC);

      // R10 new event wins over clear in same cycle
      evt_clr_i = 1'b1; step(); evt_clr_i = 1'b0;
      chk(evt_sts_o == 1'b0, "R10 cleared", evt_sts_o, 0);
      div_wr_i = 1'b1; div_data_i = 12'h321; step();
      div_wr_i = 1'b0;
      repeat (SC) step();
      evt_clr_i = 1'b1; step(); evt_clr_i = 1'b0;
      chk(evt_o == 1'b1 && evt_sts_o == 1'b1, "R10 set wins", {evt_o, evt_sts_o}, 3);

      // R3 gate low forces zero in normal mode
      gate_en_i = '0;
      for (int k = 0; k < 8; k++) begin
         step();
         chk(clk_en_o == '0, "R3 gated off", clk_en_o, 0);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule